// File: doc/BRIEF.md
# Grouped Context Model Cache

This block keeps the adaptive probability models of a binary arithmetic entropy decoder. Each model is 7 bits: a 6-bit probability state in bits 5:0 and the most-probable-symbol value in bit 6. The models are held in a 64-row single-port RAM. Each 105-bit row packs 15 models, and model position p of a row sits in bits 7p+6 down to 7p. The models are split into 25 groups, ordered by when decoding first needs them. Group 0 holds 44 models in rows 0 to 2. Group g, for g from 1 to 24, holds 8 + ((5g) mod 8) models in row g+2.

The decoder asks for a group. The block then copies that group's rows into a 44-entry register cache, one row per cycle. While the group is resident, the decoder reads models through a combinational port and writes updated models through a port that takes effect at the next edge. Neither port ever stalls. When the decoder releases the group, the block writes the group's rows back to RAM, but only if some model in the group changed. A preload port fills the RAM while no group is resident or moving. That port stands in for the table-driven initialisation done elsewhere.

Top module: `ctx_group_cache`

## Requirements
- R1: After reset, `busy` and `ready` are both 0, and they are never 1 together.
- R2: While idle (neither `busy` nor `ready`), a `pre_we` pulse writes `pre_data` to RAM row `pre_row`. The row's models are then seen when a group using that row is loaded.
- R3: A `pre_we` pulse given while a group is resident has no effect on the RAM.
- R4: A load request for a one-row group is accepted in idle. `busy` is 1 at the next cycle, and `ready` rises one cycle after that.
- R5: Loading group 0 takes three row cycles, so `ready` rises three cycles after `busy`. Cache slot s then holds position s mod 15 of row s/15.
- R6: `rd_model` shows cache slot `rd_slot` combinationally. It is 0 for any slot of 44 or above.
- R7: An update with `up_we` to a slot inside the resident group is visible on the read port at the next cycle, with no wait.
- R8: Releasing a group with no accepted update brings `busy` and `ready` both to 0 at the next cycle.
- R9: Releasing a changed group keeps `busy` high for one cycle per row of the group. During that time it writes the group's models into their RAM positions and ignores load requests.
- R10: An update to a slot at or beyond the resident group's size changes neither the cache, the RAM, nor the clean or changed state of the group.
- R11: A load request with a group number of 25 or above is ignored. A load request made while a group is resident is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pre_we | input | 1 | Preload row write strobe (honoured only while idle) |
| pre_row | input | 6 | Preload row address |
| pre_data | input | 105 | Preload row data, 15 packed models |
| load_req | input | 1 | Request to load a group |
| load_grp | input | 5 | Group number for the load request |
| release_req | input | 1 | Release the resident group |
| busy | output | 1 | A group is being loaded or written back |
| ready | output | 1 | A group is resident and the ports are live |
| rd_slot | input | 6 | Cache slot to read |
| rd_model | output | 7 | Model at `rd_slot` (combinational) |
| up_we | input | 1 | Update strobe |
| up_slot | input | 6 | Cache slot to update |
| up_model | input | 7 | New model value |

## Verification
The timing is counted from the negative edge at which a request is driven. `busy` is due at the following negative edge. `ready` is due after the group's row count plus one negative edges. After a release, idle is due one negative edge later for a clean group, or row count plus one negative edges later for a changed group. The bench counts these edges exactly and compares the count with the value computed from the group map. Read data is combinational and is sampled one time unit after the stimulus settles. An update is checked on the read port at the negative edge after the edge that stored it.

// File: rtl/ctx_cache_pkg.sv
package ctx_cache_pkg;
  localparam int MODEL_W     = 7;
  localparam int ROW_SLOTS   = 15;
  localparam int ROW_W       = MODEL_W * ROW_SLOTS;
  localparam int RAM_ROWS    = 64;
  localparam int ADDR_W      = $clog2(RAM_ROWS);
  localparam int GROUPS      = 25;
  localparam int GRP_W       = $clog2(GROUPS);
  localparam int CACHE_SLOTS = 44;
  localparam int SLOT_W      = $clog2(CACHE_SLOTS);
  localparam int BIG_ROWS    = (CACHE_SLOTS + ROW_SLOTS - 1) / ROW_SLOTS;
  localparam int CNT_W       = $clog2(BIG_ROWS + 1);
  localparam int SMALL_MIN   = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_READY, ST_WB} cache_state_e;

  function automatic logic [SLOT_W-1:0] grp_size(input logic [GRP_W-1:0] g);
    int gi;
    gi = int'(g);
    if (gi == 0) return SLOT_W'(CACHE_SLOTS);
    return SLOT_W'(SMALL_MIN + ((5 * gi) % 8));
  endfunction

  function automatic logic [ADDR_W-1:0] grp_base(input logic [GRP_W-1:0] g);
    int gi;
    gi = int'(g);
    if (gi == 0) return '0;
    return ADDR_W'(gi + BIG_ROWS - 1);
  endfunction

  function automatic logic [CNT_W-1:0] grp_rows(input logic [GRP_W-1:0] g);
    if (g == '0) return CNT_W'(BIG_ROWS);
    return CNT_W'(1);
  endfunction
endpackage

// File: rtl/ctx_model_ram.sv
module ctx_model_ram
  import ctx_cache_pkg::*;
(
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ROW_W-1:0]  wdata,
  output logic [ROW_W-1:0]  rdata
);
  logic [ROW_W-1:0] mem_q [RAM_ROWS];

  always_ff @(posedge clk) begin
    if (we) mem_q[addr] <= wdata;
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/ctx_slot_cache.sv
module ctx_slot_cache
  import ctx_cache_pkg::*;
(
  input  logic                                   clk,
  input  logic                                   load_en,
  input  logic [CNT_W-1:0]                       load_seg,
  input  logic [ROW_W-1:0]                       load_row,
  input  logic                                   up_en,
  input  logic [SLOT_W-1:0]                      up_slot,
  input  logic [MODEL_W-1:0]                     up_model,
  output logic [CACHE_SLOTS-1:0][MODEL_W-1:0]    models
);
  for (genvar s = 0; s < CACHE_SLOTS; s++) begin : g_slot
    localparam int SEG = s / ROW_SLOTS;
    localparam int POS = s % ROW_SLOTS;
    logic               en;
    logic [MODEL_W-1:0] d, q;

    always_comb begin
      en = 1'b0;
      d  = q;
      if (load_en && load_seg == CNT_W'(SEG)) begin
        en = 1'b1;
        d  = load_row[POS*MODEL_W +: MODEL_W];
      end else if (up_en && up_slot == SLOT_W'(s)) begin
        en = 1'b1;
        d  = up_model;
      end
    end

    always_ff @(posedge clk) begin
      if (en) q <= d;
    end

    assign models[s] = q;
  end
endmodule

// File: rtl/ctx_group_ctrl.sv
module ctx_group_ctrl
  import ctx_cache_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_req,
  input  logic [GRP_W-1:0] load_grp,
  input  logic             release_req,
  input  logic             up_hit,
  output cache_state_e     state_o,
  output logic [GRP_W-1:0] grp_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy,
  output logic             ready
);
  cache_state_e     state_q, state_d;
  logic [GRP_W-1:0] grp_q, grp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dirty_q, dirty_d;
  logic [CNT_W-1:0] rows;
  logic             grp_ok;

  assign rows   = grp_rows(grp_q);
  assign grp_ok = int'(load_grp) < GROUPS;

  always_comb begin
    state_d = state_q;
    grp_d   = grp_q;
    cnt_d   = cnt_q;
    dirty_d = dirty_q;
    case (state_q)
      ST_IDLE: begin
        if (load_req && grp_ok) begin
          state_d = ST_LOAD;
          grp_d   = load_grp;
          cnt_d   = '0;
          dirty_d = 1'b0;
        end
      end
      ST_LOAD: begin
        if (cnt_q == rows - 1'b1) begin
          state_d = ST_READY;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_READY: begin
        if (up_hit) dirty_d = 1'b1;
        if (release_req) begin
          cnt_d   = '0;
          state_d = (dirty_q || up_hit) ? ST_WB : ST_IDLE;
        end
      end
      ST_WB: begin
        if (cnt_q == rows - 1'b1) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
          dirty_d = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      grp_q   <= '0;
      cnt_q   <= '0;
      dirty_q <= 1'b0;
    end else begin
      state_q <= state_d;
      grp_q   <= grp_d;
      cnt_q   <= cnt_d;
      dirty_q <= dirty_d;
    end
  end

  assign state_o = state_q;
  assign grp_o   = grp_q;
  assign cnt_o   = cnt_q;
  assign busy    = (state_q == ST_LOAD) || (state_q == ST_WB);
  assign ready   = (state_q == ST_READY);

  // R1
  busy_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && ready));

  // R4
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && load_req && grp_ok) |=> busy);

  // R11
  bad_grp_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && load_req && !grp_ok) |=> (state_q == ST_IDLE));

  // R8
  clean_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READY && release_req && !dirty_q && !up_hit) |=> (state_q == ST_IDLE));

  // R9
  wb_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WB) |-> (cnt_q < rows));
endmodule

// File: rtl/ctx_group_cache.sv
module ctx_group_cache
  import ctx_cache_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pre_we,
  input  logic [ADDR_W-1:0]  pre_row,
  input  logic [ROW_W-1:0]   pre_data,
  input  logic               load_req,
  input  logic [GRP_W-1:0]   load_grp,
  input  logic               release_req,
  output logic               busy,
  output logic               ready,
  input  logic [SLOT_W-1:0]  rd_slot,
  output logic [MODEL_W-1:0] rd_model,
  input  logic               up_we,
  input  logic [SLOT_W-1:0]  up_slot,
  input  logic [MODEL_W-1:0] up_model
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  cache_state_e                         state;
  logic [GRP_W-1:0]                     cur_grp;
  logic [CNT_W-1:0]                     cnt;
  logic [SLOT_W-1:0]                    cur_size;
  logic [ADDR_W-1:0]                    cur_base;
  logic                                 up_hit;
  logic [CACHE_SLOTS-1:0][MODEL_W-1:0]  models;
  logic                                 ram_we;
  logic [ADDR_W-1:0]                    ram_addr;
  logic [ROW_W-1:0]                     ram_wdata, ram_rdata, wb_row;

  assign cur_size = grp_size(cur_grp);
  assign cur_base = grp_base(cur_grp);
  assign up_hit   = ready && up_we && (up_slot < cur_size);

  ctx_group_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .load_req    (load_req),
    .load_grp    (load_grp),
    .release_req (release_req),
    .up_hit      (up_hit),
    .state_o     (state),
    .grp_o       (cur_grp),
    .cnt_o       (cnt),
    .busy        (busy),
    .ready       (ready)
  );

  // Row merge for write-back: slots of the group from the cache, others kept.
  always_comb begin
    wb_row = ram_rdata;
    for (int s = 0; s < CACHE_SLOTS; s++) begin
      if (CNT_W'(s / ROW_SLOTS) == cnt && SLOT_W'(s) < cur_size)
        wb_row[(s % ROW_SLOTS)*MODEL_W +: MODEL_W] = models[s];
    end
  end

  always_comb begin
    if (state == ST_LOAD || state == ST_WB) ram_addr = cur_base + ADDR_W'(cnt);
    else                                    ram_addr = pre_row;
    ram_we    = (state == ST_WB) || (state == ST_IDLE && pre_we);
    ram_wdata = (state == ST_WB) ? wb_row : pre_data;
  end

  ctx_model_ram ram_i (
    .clk   (clk),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  ctx_slot_cache cache_i (
    .clk      (clk),
    .load_en  (state == ST_LOAD),
    .load_seg (cnt),
    .load_row (ram_rdata),
    .up_en    (up_hit),
    .up_slot  (up_slot),
    .up_model (up_model),
    .models   (models)
  );

  always_comb begin
    rd_model = '0;
    for (int s = 0; s < CACHE_SLOTS; s++)
      if (rd_slot == SLOT_W'(s)) rd_model = models[s];
  end

  // R10
  oor_update_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ready && up_we && up_slot >= cur_size) |=> $stable(models));

  // R3
  preload_blocked_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ready && pre_we) |-> !ram_we);
endmodule

// File: tb/ctx_group_cache_tb.sv
module ctx_group_cache_tb_top;
  import ctx_cache_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic               rst_n, pre_we, load_req, release_req, busy, ready, up_we;
  logic [ADDR_W-1:0]  pre_row;
  logic [ROW_W-1:0]   pre_data;
  logic [GRP_W-1:0]   load_grp;
  logic [SLOT_W-1:0]  rd_slot, up_slot;
  logic [MODEL_W-1:0] rd_model, up_model;

  ctx_group_cache dut_i (.*);

  logic [ROW_W-1:0]   mem_m [RAM_ROWS];
  logic [MODEL_W-1:0] cache_m [CACHE_SLOTS];
  bit                 known_m [CACHE_SLOTS];
  int  checks = 0, fails = 0;
  bit  resident = 0, dirty = 0, done = 0;
  int  cur = 0;

  function automatic int g_size(int g); return (g == 0) ? 44 : 8 + ((5*g) % 8); endfunction
  function automatic int g_base(int g); return (g == 0) ? 0 : g + 2; endfunction
  function automatic int g_rows(int g); return (g == 0) ? 3 : 1; endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic preload(input int r, input logic [ROW_W-1:0] d);
    @(negedge clk); pre_we = 1; pre_row = ADDR_W'(r); pre_data = d;
    @(negedge clk); pre_we = 0;
    if (!resident) mem_m[r] = d;   // R3: not stored while resident
  endtask

  task automatic load(input int g, input string req);
    int n;
    @(negedge clk); load_req = 1; load_grp = GRP_W'(g);
    @(negedge clk); load_req = 0;
    if (g >= GROUPS || resident) begin
      chk({req, " busy after ignored load (R11)"}, busy, 0);
      chk({req, " ready after ignored load (R11)"}, ready, resident);
      return;
    end
    chk({req, " busy after accept (R4)"}, busy, 1);
    n = 1;
    while (!ready && n < 10) begin @(negedge clk); n++; end
    chk({req, " load cycles (R4/R5)"}, n, g_rows(g) + 1);
    for (int s = 0; s < CACHE_SLOTS; s++)
      if (s / 15 < g_rows(g)) begin
        cache_m[s] = mem_m[g_base(g) + s/15][(s%15)*7 +: 7];
        known_m[s] = 1;
      end
    resident = 1; cur = g; dirty = 0;
  endtask

  task automatic read_all(input string req);
    for (int s = 0; s < 64; s++) begin
      @(negedge clk); rd_slot = SLOT_W'(s); #1;
      if (s >= CACHE_SLOTS) begin
        if (s == 50) chk({req, " read beyond cache (R6)"}, rd_model, 0);
      end else if (known_m[s]) chk({req, " read slot (R6/R2)"}, rd_model, cache_m[s]);
    end
  endtask

  task automatic upd(input int slot, input logic [6:0] m);
    @(negedge clk); up_we = 1; up_slot = SLOT_W'(slot); up_model = m;
    @(negedge clk); up_we = 0;
    if (slot < g_size(cur)) begin cache_m[slot] = m; dirty = 1; end
    rd_slot = SLOT_W'(slot); #1;
    if (slot >= CACHE_SLOTS) chk("oor update read (R10)", rd_model, 0);
    else if (known_m[slot]) chk(slot < g_size(cur) ? "update visible (R7)" : "oor update ignored (R10)",
                                rd_model, cache_m[slot]);
  endtask

  task automatic release_grp(input bit poke_load);
    int n;
    @(negedge clk); release_req = 1;
    @(negedge clk); release_req = 0;
    if (!dirty) begin
      chk("clean release busy (R8)", busy, 0);
      chk("clean release ready (R8)", ready, 0);
    end else begin
      chk("dirty release busy (R9)", busy, 1);
      chk("dirty release ready (R9)", ready, 0);
      n = 1;
      if (poke_load) begin load_req = 1; load_grp = 5; end
      while (busy && n < 10) begin @(negedge clk); load_req = 0; n++; end
      load_req = 0;
      chk("write-back cycles (R9)", n, g_rows(cur) + 1);
      for (int s = 0; s < g_size(cur); s++)
        mem_m[g_base(cur) + s/15][(s%15)*7 +: 7] = cache_m[s];
      if (poke_load) begin
        @(negedge clk);
        chk("load during write-back ignored (R9)", {busy, ready}, 0);
      end
    end
    resident = 0; dirty = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [ROW_W-1:0] r;
    void'($urandom(32'd2718));
    rst_n = 0; pre_we = 0; load_req = 0; release_req = 0; up_we = 0;
    pre_row = 0; pre_data = 0; load_grp = 0; rd_slot = 0; up_slot = 0; up_model = 0;
    for (int s = 0; s < CACHE_SLOTS; s++) begin known_m[s] = 0; cache_m[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("reset busy (R1)", busy, 0);
    chk("reset ready (R1)", ready, 0);

    // R2: preload every row
    for (int row = 0; row < RAM_ROWS; row++) begin
      r = {$urandom, $urandom, $urandom, $urandom};
      preload(row, r);
    end

    // R5: big group, with in-range and out-of-range updates
    load(0, "grp0");
    read_all("grp0");
    upd(0, 7'h55);
    upd(43, 7'h2a);
    upd(44, 7'h11);   // R10: beyond cache
    upd(60, 7'h22);   // R10
    preload(1, '1);   // R3: ignored while resident
    load(7, "load while resident");   // R11
    read_all("grp0 after updates");
    release_grp(1);
    load(0, "grp0 reload");
    read_all("grp0 reload");
    release_grp(0);

    // R10: slot past a small group's size keeps group clean
    load(2, "grp2");
    upd(12, 7'h3c);
    chk("oor update keeps clean (R10)", dirty, 0);
    release_grp(0);

    // R11: invalid group number
    load(30, "bad group");

    // random mix
    for (int it = 0; it < 30; it++) begin
      int g, k;
      g = int'($urandom % GROUPS);
      load(g, "rand");
      k = int'($urandom % 6);
      for (int u = 0; u < k; u++) begin
        int sl;
        sl = ($urandom % 2) ? int'($urandom % g_size(g)) : int'($urandom % 64);
        upd(sl, 7'($urandom));
      end
      if (it % 5 == 0) read_all("rand");
      release_grp(0);
    end

    // final sweep: every group's RAM content matches the model
    for (int g = 0; g < GROUPS; g++) begin
      load(g, "sweep");
      read_all("sweep");
      release_grp(0);
    end
    finish_run();
  end
endmodule